// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block serves one processor port of a shared interrupt controller. Each cycle it looks at every interrupt source's enable, pending, group, routing and 8-bit priority state. It picks the most urgent source that may be delivered to its processor. It then decides whether the processor's normal request line or its fast request line should be raised. One copy is instantiated per processor. Storage of the per-source state, register decoding, acknowledge and end-of-interrupt handling all live elsewhere, so the state arrives here as plain vectors.

Several conditions gate the result:
- A source is a candidate only if it is enabled, pending and routed to this processor.
- The winner is reported only if it clears the processor's priority mask.
- A line is raised only if the winner is also more urgent than the processor's running priority.
- The winner's group must be enabled both globally and for this processor.
- Group-0 winners may be steered to the fast line.

The outputs are registered, so each result is visible one cycle after the inputs that produced it. The whole result is recomputed every cycle.

Top module: `irq_prio_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pend_id` reads 1023 and both `irq_o` and `fiq_o` are low.
- R2: Source i is a candidate only if `src_enable[i]` and `src_pending[i]` are both 1. Sources with an ID below 32 are private and need no routing bit. Sources with an ID of 32 or more also need `src_route[i]` = 1, where that bit is this processor's bit of the source's target mask.
- R3: Among the candidates, the one with the numerically lowest priority wins. The priority of source i is `src_prio[8*i+7:8*i]`. On equal priority, the lowest ID wins.
- R4: `pend_id` shows the winner's ID only if the winner's priority is strictly less than `prio_mask`. Otherwise, or when there is no candidate, it shows 1023. A priority of 0xFF therefore never passes.
- R5: A request line can be raised only if the winner's priority is strictly less than `run_prio`. `run_prio` is 9 bits wide, and the value 0x100 means that no interrupt is active.
- R6: The winner's group is `src_group[i]`, with 0 meaning group 0. A request line is raised only if `dist_grp_en[g]` and `cpu_grp_en[g]` are both 1 for that group g. If the group is not enabled, `pend_id` still shows the winner but neither line rises.
- R7: A group-0 winner that qualifies raises `fiq_o` when `cpu_fiq_en` is 1. Every other qualifying winner raises `irq_o`. The two lines are never high together.
- R8: If `dist_grp_en` is 00 or `cpu_grp_en` is 00, `pend_id` is 1023 and both lines are low, whatever the source state.
- R9: The outputs follow the inputs with exactly one cycle of latency, and the result is recomputed every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_enable | input | NUM_SRC | Per-source enable for this processor |
| src_pending | input | NUM_SRC | Per-source pending for this processor |
| src_group | input | NUM_SRC | Per-source group (0 or 1) |
| src_route | input | NUM_SRC | This processor's bit of each source's target mask |
| src_prio | input | 8*NUM_SRC | Packed 8-bit priorities, source i at bits 8i+7:8i |
| dist_grp_en | input | 2 | Global group enables, bit g for group g |
| cpu_grp_en | input | 2 | This processor's group enables, bit g for group g |
| cpu_fiq_en | input | 1 | Steer group-0 winners to the fast line |
| prio_mask | input | 8 | Priority mask threshold |
| run_prio | input | 9 | Running priority, 0x100 when idle |
| pend_id | output | 10 | Registered selected ID, 1023 when none |
| irq_o | output | 1 | Registered normal request line |
| fiq_o | output | 1 | Registered fast request line |

## Verification
Because there is only one register stage, a wrong choice inside the reduction tree shows up on `pend_id` in the very next cycle. A wrong tie-break shows as a higher ID being reported when two sources share a priority. An off-by-one in either threshold comparison shows only when a priority equals the mask or the running priority exactly. The scenarios therefore place values right on those boundaries. A wrong group or steering decision shows as the wrong line, or no line, one cycle after the inputs change, while `pend_id` stays correct.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W  = 8;
  localparam int ID_W    = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic              valid;
    logic              grp;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } cand_t;

  // Right-hand candidate replaces the left only when strictly more urgent.
  function automatic logic right_wins(cand_t l, cand_t r);
    return r.valid && (!l.valid || (r.prio < l.prio));
  endfunction

  function automatic cand_t pick(cand_t l, cand_t r);
    return right_wins(l, r) ? r : l;
  endfunction

  function automatic logic below(logic [PRIO_W:0] val, logic [PRIO_W:0] lim);
    return val < lim;
  endfunction
endpackage

// File: rtl/irq_cand_qual.sv
module irq_cand_qual
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int PRIV_CNT = 32
) (
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC-1:0]        src_pending,
  input  logic [NUM_SRC-1:0]        src_group,
  input  logic [NUM_SRC-1:0]        src_route,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  output cand_t [NUM_SRC-1:0]       cand_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic IS_PRIV = (i < PRIV_CNT);
    logic routed;
    assign routed = src_route[i] | IS_PRIV;
    assign cand_o[i].valid = src_enable[i] & src_pending[i] & routed;
    assign cand_o[i].grp   = src_group[i];
    assign cand_o[i].prio  = src_prio[i*PRIO_W +: PRIO_W];
    assign cand_o[i].id    = ID_W'(i);
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  cand_t [NUM_SRC-1:0] cand_i,
  output cand_t               win_o
);
  localparam int LVLS   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
  localparam int LEAVES = 1 << LVLS;

  // Heap layout: node k has children 2k (lower IDs) and 2k+1.
  cand_t node [1:2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      assign node[LEAVES+i] = cand_i[i];
    end else begin : g_pad
      assign node[LEAVES+i] = '0;
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    assign node[k] = pick(node[2*k], node[2*k+1]);
  end

  assign win_o = node[1];
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_arb_pkg::*;
(
  input  cand_t             win_i,
  input  logic [1:0]        dist_grp_en,
  input  logic [1:0]        cpu_grp_en,
  input  logic              cpu_fiq_en,
  input  logic [PRIO_W-1:0] prio_mask,
  input  logic [PRIO_W:0]   run_prio,
  output logic              all_off,
  output logic              pass_mask,
  output logic              pass_run,
  output logic              grp_ok,
  output logic [ID_W-1:0]   nxt_id,
  output logic              nxt_irq,
  output logic              nxt_fiq
);
  logic req;

  always_comb begin
    all_off   = ~(|dist_grp_en) | ~(|cpu_grp_en);
    pass_mask = win_i.valid & below({1'b0, win_i.prio}, {1'b0, prio_mask});
    pass_run  = below({1'b0, win_i.prio}, run_prio);
    grp_ok    = dist_grp_en[win_i.grp] & cpu_grp_en[win_i.grp];
    req       = ~all_off & pass_mask & pass_run & grp_ok;
    nxt_id    = (~all_off & pass_mask) ? win_i.id : SPURIOUS_ID;
    nxt_fiq   = req & ~win_i.grp & cpu_fiq_en;
    nxt_irq   = req & ~nxt_fiq;
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int PRIV_CNT = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC-1:0]        src_pending,
  input  logic [NUM_SRC-1:0]        src_group,
  input  logic [NUM_SRC-1:0]        src_route,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [1:0]                dist_grp_en,
  input  logic [1:0]                cpu_grp_en,
  input  logic                      cpu_fiq_en,
  input  logic [PRIO_W-1:0]         prio_mask,
  input  logic [PRIO_W:0]           run_prio,
  output logic [ID_W-1:0]           pend_id,
  output logic                      irq_o,
  output logic                      fiq_o
);
  cand_t [NUM_SRC-1:0] cands;
  cand_t               win;
  logic                all_off, pass_mask, pass_run, grp_ok;
  logic [ID_W-1:0]     nxt_id;
  logic                nxt_irq, nxt_fiq;

  irq_cand_qual #(.NUM_SRC(NUM_SRC), .PRIV_CNT(PRIV_CNT)) qual_i (
    .src_enable (src_enable),
    .src_pending(src_pending),
    .src_group  (src_group),
    .src_route  (src_route),
    .src_prio   (src_prio),
    .cand_o     (cands)
  );

  irq_prio_tree #(.NUM_SRC(NUM_SRC)) tree_i (
    .cand_i(cands),
    .win_o (win)
  );

  irq_route route_i (
    .win_i      (win),
    .dist_grp_en(dist_grp_en),
    .cpu_grp_en (cpu_grp_en),
    .cpu_fiq_en (cpu_fiq_en),
    .prio_mask  (prio_mask),
    .run_prio   (run_prio),
    .all_off    (all_off),
    .pass_mask  (pass_mask),
    .pass_run   (pass_run),
    .grp_ok     (grp_ok),
    .nxt_id     (nxt_id),
    .nxt_irq    (nxt_irq),
    .nxt_fiq    (nxt_fiq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_id <= SPURIOUS_ID;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
    end else begin
      pend_id <= nxt_id;
      irq_o   <= nxt_irq;
      fiq_o   <= nxt_fiq;
    end
  end
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
  import irq_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input cand_t             win,
  input logic              all_off,
  input logic [1:0]        dist_grp_en,
  input logic [1:0]        cpu_grp_en,
  input logic              cpu_fiq_en,
  input logic [PRIO_W-1:0] prio_mask,
  input logic [PRIO_W:0]   run_prio,
  input logic [ID_W-1:0]   pend_id,
  input logic              irq_o,
  input logic              fiq_o
);
  a_r8_off_forces_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |=> (pend_id == SPURIOUS_ID) && !irq_o && !fiq_o);

  a_r4_shown_id_passed_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_id != SPURIOUS_ID) |-> $past(win.valid) && ($past(win.prio) < $past(prio_mask)));

  a_r5_line_beats_running: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> ({1'b0, $past(win.prio)} < $past(run_prio)));

  a_r6_line_group_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> ($past(win.grp)
      ? ($past(dist_grp_en[1]) && $past(cpu_grp_en[1]))
      : ($past(dist_grp_en[0]) && $past(cpu_grp_en[0]))));

  a_r7_fast_only_group0: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(cpu_fiq_en) && !$past(win.grp));

  a_r7_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));

  a_r4_line_has_id: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> (pend_id != SPURIOUS_ID));
endmodule

bind irq_prio_arb irq_prio_arb_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .win        (win),
  .all_off    (all_off),
  .dist_grp_en(dist_grp_en),
  .cpu_grp_en (cpu_grp_en),
  .cpu_fiq_en (cpu_fiq_en),
  .prio_mask  (prio_mask),
  .run_prio   (run_prio),
  .pend_id    (pend_id),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o)
);

// File: tb/irq_prio_arb_tb.sv
`timescale 1ns/1ps
module irq_prio_arb_tb_top;
  localparam int N = 48;

  logic           clk = 0;
  logic           rst_n = 0;
  logic [N-1:0]   en, pnd, grp, rte;
  logic [N*8-1:0] pri;
  logic [1:0]     dge, cge;
  logic           fen;
  logic [7:0]     pmask;
  logic [8:0]     rprio;
  logic [9:0]     pend_id;
  logic           irq_o, fiq_o;

  int n_chk = 0, n_fail = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_prio_arb #(.NUM_SRC(N), .PRIV_CNT(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_enable(en), .src_pending(pnd),
    .src_group(grp), .src_route(rte), .src_prio(pri),
    .dist_grp_en(dge), .cpu_grp_en(cge), .cpu_fiq_en(fen),
    .prio_mask(pmask), .run_prio(rprio),
    .pend_id(pend_id), .irq_o(irq_o), .fiq_o(fiq_o));

  // Reference: returns {id, irq, fiq}
  function automatic logic [11:0] model();
    int best = 256; int bid = 1023; logic bg = 0;
    logic ln = 0, fq = 0; int shown = 1023;
    if (dge == 0 || cge == 0) return {10'd1023, 2'b00};
    for (int i = 0; i < N; i++) begin
      if (en[i] && pnd[i] && (i < 32 || rte[i])) begin
        if (int'(pri[i*8 +: 8]) < best) begin
          best = int'(pri[i*8 +: 8]); bid = i; bg = grp[i];
        end
      end
    end
    if (bid != 1023 && best < int'(pmask)) begin
      shown = bid;
      if (best < int'(rprio) && dge[bg] && cge[bg]) begin
        if (!bg && fen) fq = 1; else ln = 1;
      end
    end
    return {shown[9:0], ln, fq};
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got id=%0d irq=%0b fiq=%0b, expected id=%0d irq=%0b fiq=%0b",
               tag, act[11:2], act[1], act[0], exp[11:2], exp[1], exp[0]);
    end
  endtask

  // Driver: current inputs -> expected item; design registers it at next posedge.
  task automatic step(string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0)
      check(tag_q.pop_front(), {pend_id, irq_o, fiq_o}, exp_q.pop_front());
  end

  task automatic clear_all();
    en = '0; pnd = '0; grp = '0; rte = '0; pri = '1;
    dge = 2'b11; cge = 2'b11; fen = 0; pmask = 8'hFF; rprio = 9'h100;
  endtask

  task automatic src(int id, logic [7:0] p, logic g, logic r);
    en[id] = 1; pnd[id] = 1; pri[id*8 +: 8] = p; grp[id] = g; rte[id] = r;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_all();
    src(40, 8'h10, 1, 1);
    #7;
    check("R1 reset", {pend_id, irq_o, fiq_o}, {10'd1023, 2'b00});
    @(negedge clk); rst_n = 1;
    check("R1 after release", {pend_id, irq_o, fiq_o}, {10'd1023, 2'b00});

    clear_all(); step("R4 no candidate");
    src(40, 8'h10, 1, 0); step("R2 unrouted shared source");
    rte[40] = 1;          step("R2 routed shared source");
    en[40] = 0;           step("R2 disabled source");
    clear_all(); src(5, 8'h20, 1, 0); step("R2 private skips routing");
    pnd[5] = 0;           step("R2 not pending");

    clear_all(); src(3, 8'h80, 1, 0); src(10, 8'h40, 1, 0); src(20, 8'h40, 1, 0);
    step("R3 tie keeps lowest id");
    pri[20*8 +: 8] = 8'h30; step("R3 lower value wins");
    src(N-1, 8'h00, 1, 1);  step("R3 top id most urgent");

    clear_all(); src(33, 8'h50, 1, 1);
    pmask = 8'h50; step("R4 equal to mask blocked");
    pmask = 8'h51; step("R4 just under mask");
    clear_all(); src(7, 8'hFF, 1, 0); step("R4 priority FF never passes");

    clear_all(); src(8, 8'h60, 1, 0);
    rprio = 9'h060; step("R5 equal running blocks line");
    rprio = 9'h061; step("R5 just under running");
    rprio = 9'h000; step("R5 running zero");

    clear_all(); src(9, 8'h20, 1, 0);
    dge = 2'b01; step("R6 group1 off globally");
    dge = 2'b11; cge = 2'b01; step("R6 group1 off at cpu");
    cge = 2'b10; step("R6 group1 on at cpu only");

    clear_all(); src(12, 8'h20, 0, 0);
    fen = 1; step("R7 group0 fast");
    fen = 0; step("R7 group0 normal");
    grp[12] = 1; fen = 1; step("R7 group1 stays normal");

    clear_all(); src(12, 8'h20, 0, 0);
    dge = 2'b00; step("R8 global all off");
    dge = 2'b11; cge = 2'b00; step("R8 cpu all off");

    clear_all(); src(4, 8'h10, 0, 0); fen = 1; step("R9 cycle a");
    pnd[4] = 0; src(36, 8'h90, 1, 1); step("R9 cycle b");
    pnd[36] = 0; step("R9 cycle c");

    @(negedge clk); @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule